// File: doc/BRIEF.md
# SPI Daisy-Chain Switch Loader

This block receives a 32-bit switch-state word over a chip-select-framed serial link and applies it to two banks of sixteen switch controls at once. It runs on the chip's system clock. The serial clock, select and data lines are taken as already synchronous to that clock, and their edges are found by comparing each sample with the one before. While select is low, every serial clock rise shifts one data bit into a 32-bit shift register. The bit pushed out of the far end is shown on the serial output after the following serial clock fall. Several devices can therefore share one select line, with each device's serial output feeding the next device's data input.

When select rises, the block checks how many bits arrived during the frame. If 32 or more arrived, the 32 bits received last are loaded into the switch outputs in a single clock. Bits that arrived before those 32 have already left through the serial output and are dropped here. If fewer than 32 arrived, the switches do not change. The serial output carries the previous shift contents, delayed by exactly 32 serial clocks. It is not a readback of the applied switch state.

An active-low shutdown input holds the shift register, the bit count, the serial output and all switches at zero, and it ignores serial activity for as long as it is low.

Top module: `spi_chain_loader`

## Requirements
- R1: After reset, every switch output is 0 (open), the serial output is 0 and the shift register holds all zeros.
- R2: A bit is shifted in only on a serial clock rise that is sampled while `cs_n` is low. While `cs_n` is high, serial clock edges and `din` leave the shift register unchanged.
- R3: After a serial clock fall inside a frame, `dout` shows the bit that entered 32 rises earlier. From the first clock after `cs_n` falls until the first fall, `dout` shows the most significant bit held before the frame. The first 32 bits presented in a frame are therefore the old contents, most significant bit first.
- R4: When `cs_n` rises after 32 or more bits, the switches take the last 32 bits received. Earlier bits are discarded.
- R5: Bit mapping, in the order received: bit 1 drives `sw_b[15]` (bank B switch 16), down to bit 16 on `sw_b[0]`. Bit 17 drives `sw_a[15]` (bank A switch 16), down to bit 32 on `sw_a[0]`. A 1 closes a switch and a 0 opens it.
- R6: When `cs_n` rises after fewer than 32 bits, no switch output changes.
- R7: The bit count saturates at 32, so a frame of any length of 32 bits or more commits its last 32 bits.
- R8: All switch outputs change in one clock edge: the edge that first samples `cs_n` high after a frame. At no other edge do they change, except by shutdown or reset.
- R9: While `shdn_n` is low, the switches, the shift register, the count and `dout` are held at zero, and serial activity is ignored. The first frame after release presents 32 zeros on `dout`.
- R10: A `cs_n` fall and a serial clock rise sampled at the same edge both take effect. The bit is shifted in and counted, and `dout` shows the most significant bit from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown; clears all state while low |
| sclk | input | 1 | Serial clock, synchronous to `clk` |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data in, sampled on serial clock rise |
| dout | output | 1 | Serial data out for chaining, updated after serial clock fall |
| sw_a | output | BANK_W | Bank A switch controls, bit n is switch n+1, 1 = closed |
| sw_b | output | BANK_W | Bank B switch controls, bit n is switch n+1, 1 = closed |

## Verification
Two functions can fall in the same clock: opening a frame, which captures the old most significant bit for `dout`, and shifting in a bit. The bench provokes this by driving `cs_n` low and `sclk` high at the same bench cycle at the start of a 32-bit frame. It is judged correct when the frame still commits, because the first bit was counted, and when the first `dout` bit equals the most significant bit of the previous word rather than the newly shifted data. A behavioural queue model, stepped on every clock, cross-checks `dout` and the switch word in every cycle of the run.

// File: rtl/spi_chain_loader.sv
module spi_chain_loader #(
  parameter int BANK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic [BANK_W-1:0] sw_a,
  output logic [BANK_W-1:0] sw_b
);
  localparam int WORD_W = 2 * BANK_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic              sclk_q, cs_q, dout_q;
  logic [WORD_W-1:0] shreg, sw_word;
  logic [CNT_W-1:0]  nbits;
  logic              sclk_up, sclk_dn, sel_on, sel_off, in_frame;

  assign sclk_up  = sclk & ~sclk_q;
  assign sclk_dn  = ~sclk & sclk_q;
  assign sel_on   = ~cs_n & cs_q;
  assign sel_off  = cs_n & ~cs_q;
  assign in_frame = ~cs_n & shdn_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      nbits  <= '0;
      dout_q <= 1'b0;
    end else if (!shdn_n) begin
      shreg  <= '0;
      nbits  <= '0;
      dout_q <= 1'b0;
    end else begin
      if (sel_on || (in_frame && sclk_dn))
        dout_q <= shreg[WORD_W-1];
      if (in_frame && sclk_up) begin
        shreg <= {shreg[WORD_W-2:0], din};
        if (nbits != FULL)
          nbits <= nbits + 1'b1;
      end
      if (sel_off)
        nbits <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sw_word <= '0;
    else if (!shdn_n)
      sw_word <= '0;
    else if (sel_off && nbits == FULL)
      sw_word <= shreg;
  end

  assign {sw_b, sw_a} = sw_word;
  assign dout         = dout_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n) && $past(shdn_n)) |-> $stable(shreg));

  // R4
  commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_off && nbits == FULL && shdn_n) |=> (sw_word == $past(shreg)));

  // R6
  short_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_off && nbits != FULL && shdn_n) |=> $stable(sw_word));

  // R7
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nbits <= FULL);

  // R8
  sw_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_word) |-> ($past(sel_off) || !$past(shdn_n)));

  // R9
  shdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (shreg == '0 && sw_word == '0 && !dout_q));
endmodule

// File: tb/test_spi_chain_loader.sv
module test_spi_chain_loader;
  localparam int CLK_PERIOD = 10;
  localparam int BANK_W     = 16;
  localparam int WORD_W     = 2 * BANK_W;

  logic clk = 1'b0, rst_n = 1'b0, shdn_n = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic dout;
  logic [BANK_W-1:0] sw_a, sw_b;

  int n_vec = 0, n_bad = 0, cycles = 0;
  bit cap[$];
  logic [31:0] pre_sw, post_sw;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_chain_loader #(.BANK_W(BANK_W)) i_spi_chain_loader (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .sclk(sclk),
    .cs_n(cs_n), .din(din), .dout(dout), .sw_a(sw_a), .sw_b(sw_b)
  );

  // behavioural reference: queue of the last 32 bits, oldest at the front
  bit mq[$];
  int m_cnt = 0;
  logic [31:0] m_sw = '0;
  logic m_dout = 1'b0, m_sclk = 1'b0, m_cs = 1'b1;

  always @(posedge clk or negedge rst_n) begin : ref_model
    bit r, f, csf, csr;
    if (!rst_n) begin
      mq.delete();
      for (int i = 0; i < WORD_W; i++) mq.push_back(1'b0);
      m_cnt = 0; m_sw = '0; m_dout = 1'b0; m_sclk = 1'b0; m_cs = 1'b1;
    end else begin
      r   = sclk && !m_sclk;
      f   = !sclk && m_sclk;
      csf = !cs_n && m_cs;
      csr = cs_n && !m_cs;
      if (!shdn_n) begin
        for (int i = 0; i < WORD_W; i++) mq[i] = 1'b0;
        m_cnt = 0; m_sw = '0; m_dout = 1'b0;
      end else begin
        if (csf || (!cs_n && f)) m_dout = mq[0];
        if (!cs_n && r) begin
          void'(mq.pop_front());
          mq.push_back(din);
          if (m_cnt < WORD_W) m_cnt++;
        end
        if (csr) begin
          if (m_cnt >= WORD_W)
            for (int i = 0; i < WORD_W; i++) m_sw[WORD_W-1-i] = mq[i];
          m_cnt = 0;
        end
      end
      m_sclk = sclk; m_cs = cs_n;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  always @(negedge clk) begin
    cycles++;
    n_vec++;
    if (dout !== m_dout) begin
      n_bad++;
      $display("FAIL R3 per-cycle dout got %b exp %b at %0t", dout, m_dout, $time);
    end
    n_vec++;
    if ({sw_b, sw_a} !== m_sw) begin
      n_bad++;
      $display("FAIL R4 per-cycle switch word got %h exp %h at %0t", {sw_b, sw_a}, m_sw, $time);
    end
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired got %0d cycles exp <= 100000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] capw(input int off);
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[31-i] = cap[off+i];
    return w;
  endfunction

  task automatic send(input logic [127:0] data, input int n, input bit same_edge);
    cap.delete();
    if (!same_edge) begin
      @(negedge clk);
      cs_n = 1'b0;
    end
    for (int i = n - 1; i >= 0; i--) begin
      if (same_edge && i == n - 1) begin
        @(negedge clk);
        cs_n = 1'b0; din = data[i]; sclk = 1'b1;
        @(negedge clk);
        cap.push_back(dout);
      end else begin
        @(negedge clk);
        sclk = 1'b0; din = data[i];
        @(negedge clk);
        @(negedge clk);
        cap.push_back(dout);
        sclk = 1'b1;
      end
      @(negedge clk);
    end
    @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
    @(negedge clk);
    pre_sw = {sw_b, sw_a};
    cs_n = 1'b1;
    @(negedge clk);
    post_sw = {sw_b, sw_a};
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle_toggle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); din = 1'b1; sclk = 1'b1;
      @(negedge clk); @(negedge clk); sclk = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset switch word", {sw_b, sw_a}, 32'h0);
    chk("R1 reset dout", {31'h0, dout}, 32'h0);

    send(128'h8000_0001, 32, 1'b0);
    chk("R4 full frame commit", {sw_b, sw_a}, 32'h8000_0001);
    chk("R5 first bit drives bank B switch 16", {31'h0, sw_b[15]}, 32'h1);
    chk("R5 last bit drives bank A switch 1", {31'h0, sw_a[0]}, 32'h1);
    chk("R1 first frame presents reset zeros on dout", capw(0), 32'h0);
    chk("R8 switch word before select edge", pre_sw, 32'h0);
    chk("R8 switch word one clock after select edge", post_sw, 32'h8000_0001);

    send(128'h0001_8000, 32, 1'b0);
    chk("R5 bit 16 drives bank B switch 1", {16'h0, sw_b}, 32'h0001);
    chk("R5 bit 17 drives bank A switch 16", {16'h0, sw_a}, 32'h8000);
    chk("R3 frame shows previous word", capw(0), 32'h8000_0001);

    send(128'h7FFF_FFFF, 31, 1'b0);
    chk("R6 short frame leaves switches", {sw_b, sw_a}, 32'h0001_8000);

    idle_toggle(5);
    chk("R2 idle clocks leave switches", {sw_b, sw_a}, 32'h0001_8000);

    send({64'h0, 32'hDEAD_BEEF, 32'h1357_9BDF}, 64, 1'b0);
    chk("R2 shift contents held across idle clocks", capw(0), 32'h7FFF_FFFF);
    chk("R3 data reappears 32 clocks later", capw(32), 32'hDEAD_BEEF);
    chk("R4 last 32 of 64 bits committed", {sw_b, sw_a}, 32'h1357_9BDF);

    send({88'h0, 8'hA5, 32'h1234_5678}, 40, 1'b0);
    chk("R4 leading bits discarded", {sw_b, sw_a}, 32'h1234_5678);
    chk("R3 40-bit frame shows prior contents", capw(0), 32'h1357_9BDF);

    send({{88{1'b1}}, 32'hCAFE_F00D}, 120, 1'b0);
    chk("R7 long frame commits last 32", {sw_b, sw_a}, 32'hCAFE_F00D);

    send(128'h0F0F_3C3C, 32, 1'b1);
    chk("R10 coincident start still commits", {sw_b, sw_a}, 32'h0F0F_3C3C);
    chk("R10 first dout bit is old msb", {31'h0, cap[0]}, 32'h1);
    chk("R10 frame shows previous word", capw(0), 32'hCAFE_F00D);

    @(negedge clk);
    shdn_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 shutdown clears switches", {sw_b, sw_a}, 32'h0);
    chk("R9 shutdown clears dout", {31'h0, dout}, 32'h0);
    send(128'hFFFF_FFFF, 32, 1'b0);
    chk("R9 frame ignored in shutdown", {sw_b, sw_a}, 32'h0);
    shdn_n = 1'b1;
    send({64'h0, 32'h5555_AAAA, 32'h0246_8ACE}, 64, 1'b0);
    chk("R9 shift register zero after release", capw(0), 32'h0);
    chk("R9 operation resumes after release", {sw_b, sw_a}, 32'h0246_8ACE);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule